// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the 32-bit register front end of a shared-memory messaging device that links several nodes. Local software sees four word registers in a 256-byte window: an interrupt mask, an interrupt status word, a read-only word that reports this node's own position number, and a write-only doorbell. A write to the doorbell names a destination peer and a vector in one data word. The block checks both against a table of how many vectors each peer has registered. If the target is valid, it emits a one-cycle notify pulse that carries the peer and the vector. If not, it drops the write without any trace.

A level interrupt is raised while the status word ANDed with the mask is nonzero. Reading the status word hands back its value and clears it in the same access. Writing the status word replaces it outright. A local event strobe loads the value 1 into status. When the block is built for message-signalled operation, that strobe is left to other logic and the level line stays low. The per-peer vector counts are loaded through a small side configuration port.

Top module: `dbell_regblk`

## Requirements
- R1: After reset the mask and status registers read as 0, irq_o is low, ntf_valid_o is low, and every peer's vector count is 0.
- R2: irq_o is high exactly when (status AND mask) is nonzero. It follows any mask, status or event change from the clock edge that updates the register.
- R3: The mask register is at byte offset 0x00. All 32 bits are written and read back unchanged.
- R4: A read of offset 0x04 returns the status value held before the access, with rd_valid_o high one cycle after the request. The same edge clears status to 0, which can drop irq_o.
- R5: A write to offset 0x04 replaces the whole status word with the written data. Bits that were set and are written 0 become 0.
- R6: A read of offset 0x08 returns own_pos_i zero-extended to 32 bits. Writes to 0x08 change no register and produce no notify.
- R7: Write decode ignores address bits 1:0, so 0x03 reaches the mask and 0x0E reaches the doorbell. A read returns 0 with no side effect unless its address is exactly 0x00, 0x04 or 0x08. This covers the doorbell offset, unaligned addresses and offsets above 0x0C.
- R8: A write to offset 0x0C is a doorbell. Data bits 31:16 give the destination peer and bits VEC_W-1:0 (7:0 by default) give the vector. A valid doorbell raises ntf_valid_o for exactly one cycle, one cycle after the request, with ntf_peer_o and ntf_vec_o carrying those fields.
- R9: A doorbell is dropped when its peer is at or above NUM_PEERS, or its vector is at or above that peer's vector count. A dropped doorbell gives no notify and leaves mask and status unchanged.
- R10: A cycle with cfg_we_i high loads cfg_count_i (0 to 2^VEC_W) as the vector count of peer cfg_peer_i. The count takes effect for doorbells from the next cycle, and a count of 2^VEC_W makes every vector valid.
- R11: With MSG_MODE = 0, evt_i loads status with 1. If a status write or a status read arrives in the same cycle, the event wins: status is 1 afterwards, and the read still returns the old value.
- R12: With MSG_MODE = 1, evt_i leaves status unchanged and irq_o stays low. Status is still readable and writable over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address inside the register window |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data |
| own_pos_i | input | 16 | This node's position number |
| evt_i | input | 1 | Local incoming event strobe |
| cfg_we_i | input | 1 | Vector count table write enable |
| cfg_peer_i | input | PEER_W | Peer whose vector count is written |
| cfg_count_i | input | VEC_W+1 | Number of vectors registered by that peer |
| irq_o | output | 1 | Level interrupt |
| ntf_valid_o | output | 1 | One-cycle notify pulse for a valid doorbell |
| ntf_peer_o | output | 16 | Notified destination peer |
| ntf_vec_o | output | VEC_W | Notified vector |

## Verification
The bench builds two instances. The main one keeps the defaults (NUM_PEERS = 16, VEC_W = 8, MSG_MODE = 0). This allows peer 15 with a full count of 256 vectors, so the largest vector 255 can be checked against the top of the count range, and it allows peer 16, the first peer that is out of range. The second instance uses NUM_PEERS = 4 with MSG_MODE = 1. It exercises the generate branch where the event strobe has no effect and the level line stays low. The smaller peer count also gives a table index width that is not the default.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
   // Width of the peer identifier field carried in a doorbell word
   localparam int ID_W      = 16;
   localparam int DATA_W    = 32;
   // Word indices of the registers (byte offset / 4)
   localparam int WIDX_MASK = 0;
   localparam int WIDX_STAT = 1;
   localparam int WIDX_POS  = 2;
   localparam int WIDX_BELL = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MASK,
      SEL_STAT,
      SEL_POS,
      SEL_BELL
   } reg_sel_e;
endpackage

// File: rtl/dbell_vec_table.sv
module dbell_vec_table #(
   parameter int NUM_PEERS = 16,
   parameter int PEER_W    = 4,
   parameter int CNT_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [PEER_W-1:0] cfg_peer_i,
   input  logic [CNT_W-1:0]  cfg_count_i,
   input  logic [PEER_W-1:0] look_peer_i,
   output logic [CNT_W-1:0]  look_cnt_o
);
   logic [CNT_W-1:0] cnt_q [NUM_PEERS];

   for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q[p] <= '0;
         end else if (cfg_we_i && (cfg_peer_i == PEER_W'(p))) begin
            cnt_q[p] <= cfg_count_i;
         end
      end
   end

   // Indices past the last peer read as zero vectors
   always_comb begin
      look_cnt_o = '0;
      for (int p = 0; p < NUM_PEERS; p++) begin
         if (look_peer_i == PEER_W'(p)) begin
            look_cnt_o = cnt_q[p];
         end
      end
   end
endmodule

// File: rtl/dbell_gate.sv
module dbell_gate
   import dbell_pkg::*;
#(
   parameter int NUM_PEERS = 16,
   parameter int PEER_W    = 4,
   parameter int VEC_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [ID_W-1:0]   dest_i,
   input  logic [VEC_W-1:0]  vec_i,
   output logic [PEER_W-1:0] look_peer_o,
   input  logic [VEC_W:0]    look_cnt_i,
   output logic              ntf_valid_o,
   output logic [ID_W-1:0]   ntf_peer_o,
   output logic [VEC_W-1:0]  ntf_vec_o
);
   localparam logic [ID_W:0] PEER_LIM = (ID_W+1)'(NUM_PEERS);

   logic peer_ok;
   logic vec_ok;
   logic accept;

   assign look_peer_o = dest_i[PEER_W-1:0];
   assign peer_ok     = {1'b0, dest_i} < PEER_LIM;
   assign vec_ok      = {1'b0, vec_i} < look_cnt_i;
   assign accept      = fire_i && peer_ok && vec_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ntf_valid_o <= 1'b0;
         ntf_peer_o  <= '0;
         ntf_vec_o   <= '0;
      end else begin
         ntf_valid_o <= accept;
         if (accept) begin
            ntf_peer_o <= dest_i;
            ntf_vec_o  <= vec_i;
         end
      end
   end
endmodule

// File: rtl/dbell_irq_core.sv
module dbell_irq_core
   import dbell_pkg::*;
#(
   parameter bit MSG_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mask_i,
   input  logic              wr_stat_i,
   input  logic              rd_stat_i,
   input  logic              evt_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] stat_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] stat_bus;
   logic              evt_hit;

   // Bus effect on status first; the event overrides it
   always_comb begin
      stat_bus = stat_q;
      if (wr_stat_i) begin
         stat_bus = wdata_i;
      end else if (rd_stat_i) begin
         stat_bus = '0;
      end
   end

   if (MSG_MODE) begin : g_msg
      logic unused_evt;
      assign unused_evt = evt_i;
      assign evt_hit    = 1'b0;
      assign irq_o      = 1'b0;
   end else begin : g_line
      assign evt_hit = evt_i;
      assign irq_o   = |(stat_q & mask_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr_mask_i) begin
            mask_q <= wdata_i;
         end
         stat_q <= evt_hit ? DATA_W'(1) : stat_bus;
      end
   end

   assign mask_o = mask_q;
   assign stat_o = stat_q;
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
   import dbell_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_PEERS = 16,
   parameter int VEC_W     = 8,
   parameter bit MSG_MODE  = 1'b0,
   localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   output logic              rd_valid_o,
   output logic [31:0]       rd_data_o,
   input  logic [15:0]       own_pos_i,
   input  logic              evt_i,
   input  logic              cfg_we_i,
   input  logic [PEER_W-1:0] cfg_peer_i,
   input  logic [VEC_W:0]    cfg_count_i,
   output logic              irq_o,
   output logic              ntf_valid_o,
   output logic [15:0]       ntf_peer_o,
   output logic [VEC_W-1:0]  ntf_vec_o
);
   localparam int WORD_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover at least four word registers");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("VEC_W must lie in 1..16 so the vector field stays below bit 16");
   end
   if (NUM_PEERS < 1 || NUM_PEERS > 65536) begin : g_bad_peers
      $error("NUM_PEERS must lie in 1..65536");
   end

   reg_sel_e          wsel;
   reg_sel_e          rsel;
   logic [WORD_W-1:0] waddr_word;
   logic              wr_go;
   logic              rd_go;
   logic [31:0]       mask_v;
   logic [31:0]       stat_v;
   logic [PEER_W-1:0] look_peer;
   logic [VEC_W:0]    look_cnt;
   logic [31:0]       rd_mux;

   assign wr_go      = req_valid_i &&  req_write_i;
   assign rd_go      = req_valid_i && !req_write_i;
   assign waddr_word = req_addr_i[ADDR_W-1:2];

   // Writes: byte lanes ignored, word index decoded
   always_comb begin
      unique case (waddr_word)
         WORD_W'(WIDX_MASK): wsel = SEL_MASK;
         WORD_W'(WIDX_STAT): wsel = SEL_STAT;
         WORD_W'(WIDX_POS):  wsel = SEL_POS;
         WORD_W'(WIDX_BELL): wsel = SEL_BELL;
         default:            wsel = SEL_NONE;
      endcase
   end

   // Reads: full byte address must match
   always_comb begin
      unique case (req_addr_i)
         ADDR_W'(WIDX_MASK * 4): rsel = SEL_MASK;
         ADDR_W'(WIDX_STAT * 4): rsel = SEL_STAT;
         ADDR_W'(WIDX_POS * 4):  rsel = SEL_POS;
         default:                rsel = SEL_NONE;
      endcase
   end

   dbell_irq_core #(
      .MSG_MODE (MSG_MODE)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mask_i (wr_go && (wsel == SEL_MASK)),
      .wr_stat_i (wr_go && (wsel == SEL_STAT)),
      .rd_stat_i (rd_go && (rsel == SEL_STAT)),
      .evt_i     (evt_i),
      .wdata_i   (req_wdata_i),
      .mask_o    (mask_v),
      .stat_o    (stat_v),
      .irq_o     (irq_o)
   );

   dbell_vec_table #(
      .NUM_PEERS (NUM_PEERS),
      .PEER_W    (PEER_W),
      .CNT_W     (VEC_W + 1)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (cfg_we_i),
      .cfg_peer_i  (cfg_peer_i),
      .cfg_count_i (cfg_count_i),
      .look_peer_i (look_peer),
      .look_cnt_o  (look_cnt)
   );

   dbell_gate #(
      .NUM_PEERS (NUM_PEERS),
      .PEER_W    (PEER_W),
      .VEC_W     (VEC_W)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (wr_go && (wsel == SEL_BELL)),
      .dest_i      (req_wdata_i[31:16]),
      .vec_i       (req_wdata_i[VEC_W-1:0]),
      .look_peer_o (look_peer),
      .look_cnt_i  (look_cnt),
      .ntf_valid_o (ntf_valid_o),
      .ntf_peer_o  (ntf_peer_o),
      .ntf_vec_o   (ntf_vec_o)
   );

   always_comb begin
      unique case (rsel)
         SEL_MASK: rd_mux = mask_v;
         SEL_STAT: rd_mux = stat_v;
         SEL_POS:  rd_mux = {16'h0, own_pos_i};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_go;
         rd_data_o  <= rd_go ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/dbell_regblk_chk.sv
module dbell_regblk_chk #(
   parameter int ADDR_W    = 8,
   parameter int NUM_PEERS = 16,
   parameter int VEC_W     = 8,
   parameter bit MSG_MODE  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid_i,
   input logic              req_write_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic [31:0]       req_wdata_i,
   input logic              rd_valid_o,
   input logic [31:0]       rd_data_o,
   input logic              evt_i,
   input logic              irq_o,
   input logic              ntf_valid_o,
   input logic [15:0]       ntf_peer_o
);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(8);
   localparam logic [16:0]       LIM    = 17'(NUM_PEERS);

   // R2
   mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && req_write_i && req_addr_i[ADDR_W-1:2] == '0
            && req_wdata_i == '0) |-> !irq_o);

   // R4
   rd_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid_i && !req_write_i && req_addr_i == A_STAT && !evt_i)
      |-> !irq_o);

   // R7
   unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && $past(req_addr_i != A_MASK && req_addr_i != A_STAT
                           && req_addr_i != A_POS)) |-> rd_data_o == '0);

   // R4
   rd_valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(req_valid_i && !req_write_i));

   // R8
   ntf_from_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid_o |-> $past(req_valid_i && req_write_i
                            && req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3)));

   // R9
   ntf_peer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid_o |-> {1'b0, ntf_peer_o} < LIM);

   // R12
   msg_mode_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (MSG_MODE && $past(rst_n)) |-> !irq_o);
endmodule

bind dbell_regblk dbell_regblk_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_PEERS (NUM_PEERS),
   .VEC_W     (VEC_W),
   .MSG_MODE  (MSG_MODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_write_i (req_write_i),
   .req_addr_i  (req_addr_i),
   .req_wdata_i (req_wdata_i),
   .rd_valid_o  (rd_valid_o),
   .rd_data_o   (rd_data_o),
   .evt_i       (evt_i),
   .irq_o       (irq_o),
   .ntf_valid_o (ntf_valid_o),
   .ntf_peer_o  (ntf_peer_o)
);

// File: tb/tb_dbell_regblk.sv
module tb_dbell_regblk;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] MY_POS = 16'h00A7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Main instance: defaults
   logic        a_v = 0, a_w = 0, a_evt = 0, a_cwe = 0;
   logic [7:0]  a_addr = 0;
   logic [31:0] a_wd = 0;
   logic [3:0]  a_cpeer = 0;
   logic [8:0]  a_ccnt = 0;
   logic        a_rv, a_irq, a_nv;
   logic [31:0] a_rd;
   logic [15:0] a_np;
   logic [7:0]  a_nvec;

   dbell_regblk dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(a_v), .req_write_i(a_w), .req_addr_i(a_addr),
      .req_wdata_i(a_wd), .rd_valid_o(a_rv), .rd_data_o(a_rd),
      .own_pos_i(MY_POS), .evt_i(a_evt),
      .cfg_we_i(a_cwe), .cfg_peer_i(a_cpeer), .cfg_count_i(a_ccnt),
      .irq_o(a_irq), .ntf_valid_o(a_nv), .ntf_peer_o(a_np), .ntf_vec_o(a_nvec)
   );

   // Second instance: message-signalled, four peers
   logic        b_v = 0, b_w = 0, b_evt = 0;
   logic [7:0]  b_addr = 0;
   logic [31:0] b_wd = 0;
   logic        b_rv, b_irq, b_nv;
   logic [31:0] b_rd;
   logic [15:0] b_np;
   logic [7:0]  b_nvec;

   dbell_regblk #(.NUM_PEERS(4), .MSG_MODE(1'b1)) dut_msg (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(b_v), .req_write_i(b_w), .req_addr_i(b_addr),
      .req_wdata_i(b_wd), .rd_valid_o(b_rv), .rd_data_o(b_rd),
      .own_pos_i(16'h0003), .evt_i(b_evt),
      .cfg_we_i(1'b0), .cfg_peer_i(2'd0), .cfg_count_i(9'd0),
      .irq_o(b_irq), .ntf_valid_o(b_nv), .ntf_peer_o(b_np), .ntf_vec_o(b_nvec)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One access on the main instance; results sampled at the next falling edge
   task automatic a_op(input logic wr, input logic [7:0] addr, input logic [31:0] d,
                       input logic evt, output logic [31:0] rdat);
      @(negedge clk);
      a_v = 1'b1; a_w = wr; a_addr = addr; a_wd = d; a_evt = evt;
      @(negedge clk);
      a_v = 1'b0; a_w = 1'b0; a_evt = 1'b0;
      rdat = a_rd;
   endtask

   task automatic a_wr(input logic [7:0] addr, input logic [31:0] d);
      logic [31:0] x;
      a_op(1'b1, addr, d, 1'b0, x);
   endtask

   task automatic a_rdchk(input string req, input logic [7:0] addr, input logic [31:0] exp);
      logic [31:0] x;
      a_op(1'b0, addr, 32'h0, 1'b0, x);
      check(req, "rd_valid", {31'h0, a_rv}, 32'h1);
      check(req, "read data", x, exp);
   endtask

   task automatic a_cfg(input logic [3:0] peer, input logic [8:0] cnt);
      @(negedge clk);
      a_cwe = 1'b1; a_cpeer = peer; a_ccnt = cnt;
      @(negedge clk);
      a_cwe = 1'b0;
   endtask

   task automatic a_bell(input string req, input logic [7:0] addr, input logic [31:0] d,
                         input logic hit, input logic [15:0] ep, input logic [7:0] ev);
      a_wr(addr, d);
      check(req, "notify valid", {31'h0, a_nv}, {31'h0, hit});
      if (hit) begin
         check(req, "notify peer", {16'h0, a_np}, {16'h0, ep});
         check(req, "notify vector", {24'h0, a_nvec}, {24'h0, ev});
      end
      @(negedge clk);
      check(req, "notify one cycle", {31'h0, a_nv}, 32'h0);
   endtask

   task automatic b_op(input logic wr, input logic [7:0] addr, input logic [31:0] d,
                       input logic evt, output logic [31:0] rdat);
      @(negedge clk);
      b_v = 1'b1; b_w = wr; b_addr = addr; b_wd = d; b_evt = evt;
      @(negedge clk);
      b_v = 1'b0; b_w = 1'b0; b_evt = 1'b0;
      rdat = b_rd;
   endtask

   task automatic t_reset();
      check("R1", "irq after reset", {31'h0, a_irq}, 32'h0);
      check("R1", "notify after reset", {31'h0, a_nv}, 32'h0);
      a_rdchk("R1", 8'h00, 32'h0);
      a_rdchk("R1", 8'h04, 32'h0);
      a_bell("R1", 8'h0C, 32'h0000_0000, 1'b0, 16'h0, 8'h0);
   endtask

   task automatic t_mask();
      a_wr(8'h00, 32'hA5A5_5A5A);
      a_rdchk("R3", 8'h00, 32'hA5A5_5A5A);
      check("R2", "irq with zero status", {31'h0, a_irq}, 32'h0);
      a_wr(8'h00, 32'hFFFF_FFFF);
      a_rdchk("R3", 8'h00, 32'hFFFF_FFFF);
   endtask

   task automatic t_irq();
      a_wr(8'h00, 32'h0000_0004);
      a_wr(8'h04, 32'h0000_0004);
      check("R2", "irq masked bit set", {31'h0, a_irq}, 32'h1);
      a_wr(8'h00, 32'h0);
      check("R2", "irq after mask cleared", {31'h0, a_irq}, 32'h0);
      a_wr(8'h00, 32'h0000_0004);
      check("R2", "irq after mask restored", {31'h0, a_irq}, 32'h1);
      a_wr(8'h04, 32'h0000_0003);
      check("R5", "irq after status overwrite", {31'h0, a_irq}, 32'h0);
      a_rdchk("R5", 8'h04, 32'h0000_0003);
   endtask

   task automatic t_rdclear();
      a_wr(8'h00, 32'h0000_0010);
      a_wr(8'h04, 32'h8000_0010);
      check("R2", "irq before read", {31'h0, a_irq}, 32'h1);
      a_rdchk("R4", 8'h04, 32'h8000_0010);
      check("R4", "irq dropped by read", {31'h0, a_irq}, 32'h0);
      a_rdchk("R4", 8'h04, 32'h0);
   endtask

   task automatic t_pos();
      a_rdchk("R6", 8'h08, {16'h0, MY_POS});
      a_bell("R6", 8'h08, 32'h0003_0000, 1'b0, 16'h0, 8'h0);
      a_rdchk("R6", 8'h08, {16'h0, MY_POS});
      a_rdchk("R6", 8'h00, 32'h0000_0010);
   endtask

   task automatic t_unmapped();
      a_wr(8'h04, 32'h0000_0007);
      a_rdchk("R7", 8'h05, 32'h0);
      a_rdchk("R7", 8'h0C, 32'h0);
      a_rdchk("R7", 8'h40, 32'h0);
      a_rdchk("R7", 8'h04, 32'h0000_0007);
      a_wr(8'h03, 32'h0000_0099);
      a_rdchk("R7", 8'h00, 32'h0000_0099);
      a_wr(8'h20, 32'h1234_5678);
      a_rdchk("R7", 8'h00, 32'h0000_0099);
   endtask

   task automatic t_bell();
      a_cfg(4'd3, 9'd2);
      a_bell("R8", 8'h0C, 32'h0003_0001, 1'b1, 16'h0003, 8'h01);
      a_bell("R7", 8'h0E, 32'h0003_FF00, 1'b1, 16'h0003, 8'h00);
      a_cfg(4'd15, 9'd256);
      a_bell("R10", 8'h0C, 32'h000F_00FF, 1'b1, 16'h000F, 8'hFF);
   endtask

   task automatic t_drop();
      a_wr(8'h00, 32'h0000_00F0);
      a_wr(8'h04, 32'h0000_0020);
      a_bell("R9", 8'h0C, 32'h0003_0002, 1'b0, 16'h0, 8'h0);
      a_bell("R9", 8'h0C, 32'h0010_0000, 1'b0, 16'h0, 8'h0);
      a_bell("R10", 8'h0C, 32'h0005_0000, 1'b0, 16'h0, 8'h0);
      a_rdchk("R9", 8'h00, 32'h0000_00F0);
      a_rdchk("R9", 8'h04, 32'h0000_0020);
      a_cfg(4'd5, 9'd1);
      a_bell("R10", 8'h0C, 32'h0005_0000, 1'b1, 16'h0005, 8'h00);
   endtask

   task automatic t_evt();
      logic [31:0] x;
      a_wr(8'h00, 32'h0000_0001);
      @(negedge clk); a_evt = 1'b1;
      @(negedge clk); a_evt = 1'b0;
      check("R11", "irq after event", {31'h0, a_irq}, 32'h1);
      a_rdchk("R11", 8'h04, 32'h0000_0001);
      a_op(1'b1, 8'h04, 32'h0000_0008, 1'b1, x);
      a_rdchk("R11", 8'h04, 32'h0000_0001);
      a_wr(8'h04, 32'h0000_0040);
      a_op(1'b0, 8'h04, 32'h0, 1'b1, x);
      check("R11", "read with event returns old", x, 32'h0000_0040);
      a_rdchk("R11", 8'h04, 32'h0000_0001);
   endtask

   task automatic t_msg();
      logic [31:0] x;
      b_op(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, x);
      @(negedge clk); b_evt = 1'b1;
      @(negedge clk); b_evt = 1'b0;
      check("R12", "irq in message mode", {31'h0, b_irq}, 32'h0);
      b_op(1'b0, 8'h04, 32'h0, 1'b0, x);
      check("R12", "event ignored", x, 32'h0);
      b_op(1'b1, 8'h04, 32'h0000_0005, 1'b0, x);
      check("R12", "irq with status set", {31'h0, b_irq}, 32'h0);
      b_op(1'b0, 8'h04, 32'h0, 1'b0, x);
      check("R12", "status still writable", x, 32'h0000_0005);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_irq();
      t_rdclear();
      t_pos();
      t_unmapped();
      t_bell();
      t_drop();
      t_evt();
      t_msg();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule